// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a pipeline's memory stage and a 32-bit data bus. It carries out the data steering for the two access sizes the machine has, a single byte and a full aligned word. One bank of per-lane byte multiplexers is shared by both directions. On a store, the multiplexers place the source byte in the lane chosen by the low address bits, fill the other lanes with zeros and produce matching byte write enables. On a load, the same multiplexers pull the addressed bus byte down into the least significant position and sign-extend it. Word data crosses the unit unchanged.

All outputs are registered. Bus-side store outputs, meaning write data, byte enables and write strobe, appear one clock after the request. Load results are captured into a write-back register together with the destination register number, also one clock after the request, and the bus read data is sampled in the request cycle. A word request whose low address bits are not zero is reported as misaligned, and it has no effect on the bus or the register file.

Top module: `lane_align_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `bus_we`, `bus_be`, `bus_wdata`, `misalign`, `wb_valid`, `wb_data` and `wb_dst` are all zero.
- R2: A word load (`acc_en`=1, `acc_wr`=0, `acc_byte`=0) with `acc_addr[1:0]`=00 gives `wb_valid`=1, `wb_data` equal to `bus_rdata` as sampled in the request cycle, and `wb_dst` equal to `acc_dst`, one cycle later.
- R3: A byte load (`acc_byte`=1) moves bus lane `acc_addr[1:0]` into `wb_data[7:0]`. Lane 0 is `bus_rdata[7:0]`, lane 1 is `[15:8]`, lane 2 is `[23:16]` and lane 3 is `[31:24]`. The result appears one cycle later with `wb_valid`=1.
- R4: A byte load result has `wb_data[31:8]` all equal to bit 7 of the selected lane.
- R5: On a byte load, the three unselected bus lanes have no effect on `wb_data`.
- R6: A byte store (`acc_wr`=1, `acc_byte`=1) drives `st_data[7:0]` on lane `acc_addr[1:0]` of `bus_wdata` and zeros on every other lane, one cycle later. `st_data[31:8]` is ignored.
- R7: A byte store gives `bus_be` with only bit `acc_addr[1:0]` set. A word store gives `bus_be`=1111. Both give `bus_we`=1, one cycle after the request.
- R8: An aligned word store drives `bus_wdata` equal to `st_data`, one cycle later.
- R9: A word access with `acc_addr[1:0]`≠00 gives `misalign`=1 one cycle later. It also gives `bus_we`=0, `bus_be`=0, `bus_wdata`=0 and `wb_valid`=0, and leaves `wb_data` and `wb_dst` unchanged.
- R10: With `acc_en`=0, the next cycle has `bus_we`=0, `bus_be`=0, `bus_wdata`=0, `misalign`=0 and `wb_valid`=0, while `wb_data` and `wb_dst` hold their previous values.
- R11: A load never asserts `bus_we` or any `bus_be` bit, and a byte access never raises `misalign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request valid this cycle |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_addr | input | 24 | Byte address of the access |
| acc_dst | input | 4 | Destination register number for loads |
| st_data | input | 32 | Store source data |
| bus_rdata | input | 32 | Read data from the bus |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_be | output | 4 | Per-lane byte write enables |
| bus_we | output | 1 | Write strobe |
| misalign | output | 1 | Misaligned word access flag |
| wb_valid | output | 1 | Write-back result valid |
| wb_dst | output | 4 | Write-back destination register |
| wb_data | output | 32 | Aligned, sign-extended load result |

## Verification
The property that is hardest to show from the ports is that unselected bus lanes have no effect on a byte load. A fixed read pattern can match the correct answer even when the wrong lane is picked. For that reason, each lane is loaded several times with random bytes on the other three lanes, and with selected bytes on both sides of the sign boundary (0x7F, 0x80, 0x00, 0xFF). The cases of misaligned word accesses are the second hard-to-reach area. Each nonzero offset is tried for both loads and stores, directly after a valid load, so that the check also covers a write-back register that must hold its value. A long random phase then mixes every access kind, idle cycles included, against the reference model.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [1:0] {
    MODE_WORD   = 2'd0,
    MODE_BLOAD  = 2'd1,
    MODE_BSTORE = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/lane_mux.sv
module lane_mux
  import align_pkg::*;
#(
  parameter int LANE_IDX = 0,
  parameter int LANES    = 4,
  parameter int SEL_W    = 2
) (
  input  lane_mode_e       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [7:0]       src_bytes [LANES],
  input  logic [7:0]       fill_byte,
  output logic [7:0]       lane_byte
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(LANE_IDX);

  always_comb begin
    case (mode)
      MODE_WORD:   lane_byte = src_bytes[LANE_IDX];
      MODE_BLOAD:  lane_byte = (LANE_IDX == 0) ? src_bytes[sel] : fill_byte;
      MODE_BSTORE: lane_byte = (sel == MY_SEL) ? src_bytes[0] : 8'h00;
      default:     lane_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/be_gen.sv
module be_gen #(
  parameter int LANES = 4,
  parameter int SEL_W = 2
) (
  input  logic             en,
  input  logic             wr,
  input  logic             is_byte,
  input  logic [SEL_W-1:0] sel,
  output logic [LANES-1:0] be,
  output logic             we,
  output logic             bad_align,
  output logic             ld_ok
);
  always_comb begin
    bad_align = en && !is_byte && (sel != '0);
    we        = en && wr && !bad_align;
    ld_ok     = en && !wr && !bad_align;
    be        = '0;
    if (we) begin
      if (is_byte) be[sel] = 1'b1;
      else         be     = '1;
    end
  end
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_byte,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_AW-1:0] acc_dst,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W/8-1:0] bus_be,
  output logic              bus_we,
  output logic              misalign,
  output logic              wb_valid,
  output logic [REG_AW-1:0] wb_dst,
  output logic [DATA_W-1:0] wb_data
);
  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);

  logic [SEL_W-1:0] sel;
  lane_mode_e       mode;
  logic [7:0]       src_bytes [LANES];
  logic [7:0]       rd_bytes  [LANES];
  logic [7:0]       fill_byte;
  logic [DATA_W-1:0] aligned;
  logic [LANES-1:0] be_c;
  logic             we_c, bad_c, ld_c;

  assign sel = acc_addr[SEL_W-1:0];

  always_comb begin
    if (!acc_byte)   mode = MODE_WORD;
    else if (acc_wr) mode = MODE_BSTORE;
    else             mode = MODE_BLOAD;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign rd_bytes[g]  = bus_rdata[g*8 +: 8];
      assign src_bytes[g] = acc_wr ? st_data[g*8 +: 8] : bus_rdata[g*8 +: 8];
      lane_mux #(.LANE_IDX(g), .LANES(LANES), .SEL_W(SEL_W)) u_mux (
        .mode      (mode),
        .sel       (sel),
        .src_bytes (src_bytes),
        .fill_byte (fill_byte),
        .lane_byte (aligned[g*8 +: 8])
      );
    end
  endgenerate

  assign fill_byte = {8{rd_bytes[sel][7]}};

  be_gen #(.LANES(LANES), .SEL_W(SEL_W)) u_be (
    .en        (acc_en),
    .wr        (acc_wr),
    .is_byte   (acc_byte),
    .sel       (sel),
    .be        (be_c),
    .we        (we_c),
    .bad_align (bad_c),
    .ld_ok     (ld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wdata <= '0;
      bus_be    <= '0;
      bus_we    <= 1'b0;
      misalign  <= 1'b0;
      wb_valid  <= 1'b0;
      wb_dst    <= '0;
      wb_data   <= '0;
    end else begin
      bus_wdata <= we_c ? aligned : '0;
      bus_be    <= be_c;
      bus_we    <= we_c;
      misalign  <= bad_c;
      wb_valid  <= ld_c;
      if (ld_c) begin
        wb_data <= aligned;
        wb_dst  <= acc_dst;
      end
    end
  end
endmodule

// File: rtl/lane_align_checks.sv
module lane_align_checks #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              acc_wr,
  input logic              acc_byte,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] st_data,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W/8-1:0] bus_be,
  input logic              bus_we,
  input logic              misalign,
  input logic              wb_valid,
  input logic [DATA_W-1:0] wb_data
);
  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);

  p_byte_be_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_wr && acc_byte |=> bus_we && $countones(bus_be) == 1);

  p_load_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    acc_en && !acc_wr |=> !bus_we && bus_be == '0);

  p_byte_never_misaligned_r11: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_byte |=> !misalign);

  p_misalign_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    misalign |-> !bus_we && bus_be == '0 && !wb_valid);

  p_sign_fill_r4: assert property (@(posedge clk) disable iff (rst)
    acc_en && !acc_wr && acc_byte |=> wb_data[DATA_W-1:8] == {(DATA_W-8){wb_data[7]}});

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !bus_we && !wb_valid && !misalign && $stable(wb_data));

  p_word_store_pass_r8: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_wr && !acc_byte && acc_addr[SEL_W-1:0] == '0
    |=> bus_wdata == $past(st_data) && bus_be == '1);
endmodule

bind lane_align_unit lane_align_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
) u_checks (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_byte(acc_byte),
  .acc_addr(acc_addr), .st_data(st_data), .bus_wdata(bus_wdata), .bus_be(bus_be),
  .bus_we(bus_we), .misalign(misalign), .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/lane_align_unit_bench.sv
`timescale 1ns/1ps
module lane_align_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 0, acc_wr = 0, acc_byte = 0;
  logic [23:0] acc_addr = '0;
  logic [3:0]  acc_dst = '0;
  logic [31:0] st_data = '0, bus_rdata = '0;
  logic [31:0] bus_wdata, wb_data;
  logic [3:0]  bus_be, wb_dst;
  logic        bus_we, misalign, wb_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] e_wdata = 0, e_wbdata = 0;
  logic [3:0]  e_be = 0, e_dst = 0;
  logic        e_we = 0, e_mis = 0, e_wbv = 0;

  always #10 clk = ~clk;

  lane_align_unit u_lane_align_unit (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_byte(acc_byte),
    .acc_addr(acc_addr), .acc_dst(acc_dst), .st_data(st_data), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_we(bus_we), .misalign(misalign),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int a = int'(acc_addr[1:0]);
    logic [7:0] b;
    if (rst) begin
      e_wdata = 0; e_be = 0; e_we = 0; e_mis = 0; e_wbv = 0; e_wbdata = 0; e_dst = 0;
    end else begin
      e_mis = acc_en && !acc_byte && (a != 0);
      e_we = 0; e_be = 0; e_wdata = 0; e_wbv = 0;
      if (acc_en && !e_mis) begin
        if (acc_wr) begin
          e_we = 1;
          if (acc_byte) begin
            e_be = 4'(1 << a);
            e_wdata = 32'(st_data[7:0]) << (8 * a);
          end else begin
            e_be = 4'hF;
            e_wdata = st_data;
          end
        end else begin
          e_wbv = 1;
          e_dst = acc_dst;
          if (acc_byte) begin
            b = bus_rdata[8*a +: 8];
            e_wbdata = {{24{b[7]}}, b};
          end else e_wbdata = bus_rdata;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "bus_wdata", bus_wdata, e_wdata);
    chk(tag, "bus_be", 32'(bus_be), 32'(e_be));
    chk(tag, "bus_we", 32'(bus_we), 32'(e_we));
    chk(tag, "misalign", 32'(misalign), 32'(e_mis));
    chk(tag, "wb_valid", 32'(wb_valid), 32'(e_wbv));
    chk(tag, "wb_data", wb_data, e_wbdata);
    chk(tag, "wb_dst", 32'(wb_dst), 32'(e_dst));
  endtask

  task automatic step(string tag, logic en, logic wr, logic byt, logic [23:0] addr,
                      logic [3:0] dst, logic [31:0] sd, logic [31:0] rd);
    acc_en = en; acc_wr = wr; acc_byte = byt; acc_addr = addr;
    acc_dst = dst; st_data = sd; bus_rdata = rd;
    @(posedge clk);
    model();
    #2;
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat [4] = '{8'h7F, 8'h80, 8'h00, 8'hFF};
    #3;
    // R1: reset state
    for (int i = 0; i < 3; i++) step("R1", 1, 0, 0, 24'h0, 4'h5, 32'h0, 32'hDEADBEEF);
    rst = 1'b0;
    step("R1", 0, 0, 0, 24'h0, 4'h0, 32'h0, 32'h0);
    // R2: word loads
    step("R2", 1, 0, 0, 24'h000100, 4'h3, 32'h0, 32'h89ABCDEF);
    step("R2", 1, 0, 0, 24'hFFFFFC, 4'hC, 32'h0, 32'h01234567);
    // R3/R4/R5: byte loads, every lane, sign boundary, random other lanes
    for (int ln = 0; ln < 4; ln++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 2; k++) begin
          logic [31:0] rd = $urandom;
          rd[8*ln +: 8] = pat[p];
          step(k == 0 ? "R3" : (p[0] ? "R4" : "R5"), 1, 0, 1,
               24'h000400 | 24'(ln), 4'(ln + p), 32'h0, rd);
        end
    // R6/R7: byte stores, every lane, junk in upper source bytes
    for (int ln = 0; ln < 4; ln++) begin
      step("R6", 1, 1, 1, 24'h002000 | 24'(ln), 4'h0, 32'hA5A5A500 | 32'(ln * 17 + 3), 32'h0);
      step("R7", 1, 1, 1, 24'h002000 | 24'(ln), 4'h0, $urandom, 32'h0);
    end
    // R8/R7: word stores
    step("R8", 1, 1, 0, 24'h003000, 4'h0, 32'hCAFEF00D, 32'h0);
    step("R7", 1, 1, 0, 24'h003004, 4'h0, 32'h12345678, 32'h0);
    // R9: misaligned words, after a valid load so holding is visible
    for (int off = 1; off < 4; off++) begin
      step("R2", 1, 0, 0, 24'h004000, 4'h9, 32'h0, 32'h0BADF00D + 32'(off));
      step("R9", 1, 0, 0, 24'h004000 | 24'(off), 4'h2, 32'h0, 32'hFFFFFFFF);
      step("R9", 1, 1, 0, 24'h004000 | 24'(off), 4'h2, 32'h55555555, 32'h0);
    end
    // R10: idle cycles with active-looking inputs
    step("R10", 0, 1, 1, 24'h000001, 4'h7, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step("R10", 0, 0, 1, 24'h000002, 4'h8, 32'h0, 32'h80808080);
    // R11: random mix of everything
    for (int i = 0; i < 400; i++)
      step("R11", 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           24'($urandom), 4'($urandom), $urandom, $urandom);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule